// File: doc/BRIEF.md
# Acquisition Record Formatter

This block turns each multichannel sample period into one record of fixed length and streams the records, one 16-bit word per cycle, to a storage writer that lays them down as a single sequential stream. A record opens with a ten-word metadata header. The header carries the session tag, the unit tag, a running record index and a bitmap of live front-end sources. The channel words follow: the primary channels first, then the auxiliary channels, which number three per source by default. Zero words fill the rest of the record.

Software pulses `start_i` to open a session. At that pulse the block captures the session and unit tags and clears the record index and the burst position. Each `sample_rdy_i` pulse accepted after that produces one record. The block reads the channel words from an external buffer over a read port with one-cycle latency. Markers on the output flag the first and last word of every record and of every group of `BURST_RECS` records, so the storage side can issue each group as one contiguous write. A sample strobe that arrives while a record is still being emitted produces no record and sets a sticky overrun flag.

Top module: `acq_frame_fmt`

## Requirements
- R1: Each record is exactly REC_BYTES/2 words of 16 bits, sent low byte first (byte 2k is bits 7:0 of word k). Words 0-3 hold the 64-bit session tag and words 4-5 the 32-bit unit tag. Words 6-7 hold the record index and words 8-9 the source bitmap, every field least significant half first. Words 10 onward hold buffer addresses 0 to NCH-1 in ascending order, with the primary channels at 0..PRI_CH-1 and the auxiliary channels after them. All remaining words are zero.
- R2: An accepted start makes the next record's index 0. The index then rises by one per emitted record and wraps modulo 2^32.
- R3: The session and unit tags are captured only by an accepted start. A start is accepted only when the block is not recording and no record is in progress. Tag input changes and start pulses while recording have no effect on emitted records.
- R4: The source bitmap in a record is the value of `src_active_i` in the cycle its strobe was accepted, with source s at bit s and zeros above NUM_SRC-1.
- R5: The words of a record appear on consecutive cycles with `out_valid_o` high. `out_sor_o` marks word 0 and `out_eor_o` marks the last word.
- R6: Counting records from the accepted start, `out_sob_o` marks word 0 of each record whose position modulo BURST_RECS is 0. `out_eob_o` marks the last word of each record whose position is BURST_RECS-1.
- R7: A strobe while a record is in progress starts no record and sets `overrun_o`. The flag stays set until the next accepted start clears it.
- R8: A strobe while not recording is ignored. `stop_i` ends recording at once, and a record already in progress completes in full.
- R9: `buf_rd_en_o` is high only in cycles that fetch a channel word. The word returned one cycle later is the one placed in the record.
- R10: Under reset, `out_valid_o`, `recording_o` and `overrun_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Session start pulse |
| stop_i | input | 1 | Session stop pulse |
| session_i | input | 64 | Session tag, captured at start |
| unit_i | input | 32 | Low word of the hardware address used as unit tag |
| src_active_i | input | NUM_SRC | Live-source bitmap |
| sample_rdy_i | input | 1 | Sample period ready strobe |
| buf_rd_en_o | output | 1 | Channel buffer read enable |
| buf_rd_addr_o | output | CH_AW | Channel buffer read address |
| buf_rd_data_i | input | 16 | Channel buffer read data, one cycle after the address |
| out_valid_o | output | 1 | Stream word valid |
| out_data_o | output | 16 | Stream word |
| out_sor_o | output | 1 | First word of a record |
| out_eor_o | output | 1 | Last word of a record |
| out_sob_o | output | 1 | First word of a burst |
| out_eob_o | output | 1 | Last word of a burst |
| recording_o | output | 1 | Session open |
| overrun_o | output | 1 | Sticky strobe-overrun flag |

## Verification
Records are driven with a different bitmap and a different buffer fill each time. This separates a header word placed at the wrong position from a channel word fetched from the wrong address or taken from a stale read. The bitmap input is changed right after each strobe, which shows whether it is sampled at acceptance or later. Seven records run back to back across a burst boundary, which exposes index and burst-marker errors. Further cases reuse the same stream check: a strobe while idle, a repeated start with a new tag while recording, a second strobe inside a record, a stop in mid-record and a restart. Each one produces a visible difference in the output stream or in the two status flags.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
  localparam int HDR_WORDS = 10;
  localparam int WORD_W    = 16;

  typedef enum logic [1:0] {
    WK_HDR  = 2'd0,
    WK_CHAN = 2'd1,
    WK_ZERO = 2'd2
  } word_kind_e;
endpackage

// File: rtl/sfmt_ctrl.sv
module sfmt_ctrl #(
  parameter int NUM_SRC    = 32,
  parameter int BURST_RECS = 128,
  parameter int BP_W       = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [63:0]        session_i,
  input  logic [31:0]        unit_i,
  input  logic [NUM_SRC-1:0] src_active_i,
  input  logic               sample_rdy_i,
  input  logic               busy_i,
  output logic               go_o,
  output logic               recording_o,
  output logic               overrun_o,
  output logic [63:0]        ses_o,
  output logic [31:0]        unit_o,
  output logic [31:0]        idx_o,
  output logic [31:0]        map_o,
  output logic [BP_W-1:0]    bpos_o
);
  localparam logic [BP_W-1:0] BP_LAST = BP_W'(BURST_RECS - 1);

  logic            recording_q, overrun_q;
  logic [63:0]     ses_q;
  logic [31:0]     unit_q, nxt_idx_q, cur_idx_q, map_q;
  logic [BP_W-1:0] nxt_bpos_q, cur_bpos_q;
  logic            start_ok;

  assign start_ok = start_i & ~recording_q & ~busy_i;
  assign go_o     = recording_q & sample_rdy_i & ~busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      recording_q <= 1'b0;
      overrun_q   <= 1'b0;
      ses_q       <= '0;
      unit_q      <= '0;
      nxt_idx_q   <= '0;
      cur_idx_q   <= '0;
      map_q       <= '0;
      nxt_bpos_q  <= '0;
      cur_bpos_q  <= '0;
    end else begin
      if (start_ok) begin
        recording_q <= 1'b1;
        ses_q       <= session_i;
        unit_q      <= unit_i;
        nxt_idx_q   <= '0;
        nxt_bpos_q  <= '0;
        overrun_q   <= 1'b0;
      end else if (stop_i) begin
        recording_q <= 1'b0;
      end
      if (go_o) begin
        map_q      <= 32'(src_active_i);
        cur_idx_q  <= nxt_idx_q;
        nxt_idx_q  <= nxt_idx_q + 32'd1;
        cur_bpos_q <= nxt_bpos_q;
        nxt_bpos_q <= (nxt_bpos_q == BP_LAST) ? '0 : nxt_bpos_q + BP_W'(1);
      end
      if (recording_q & sample_rdy_i & busy_i) overrun_q <= 1'b1;
    end
  end

  assign recording_o = recording_q;
  assign overrun_o   = overrun_q;
  assign ses_o       = ses_q;
  assign unit_o      = unit_q;
  assign idx_o       = cur_idx_q;
  assign map_o       = map_q;
  assign bpos_o      = cur_bpos_q;

  // R7: overrun stays set until an accepted start
  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (overrun_q && !start_ok) |=> overrun_q);

  // R3: tags frozen while the session is open
  p_tags_hold_r3: assert property (@(posedge clk) disable iff (rst)
    recording_q |=> ($stable(ses_q) && $stable(unit_q)));

  // R7: a strobe during a busy record raises the flag
  p_overrun_set_r7: assert property (@(posedge clk) disable iff (rst)
    (recording_q && sample_rdy_i && busy_i) |=> overrun_q);
endmodule

// File: rtl/sfmt_walk.sv
module sfmt_walk
  import sfmt_pkg::*;
#(
  parameter int NCH       = 1120,
  parameter int REC_WORDS = 2048,
  parameter int CH_AW     = 11,
  parameter int CNT_W     = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  output logic             busy_o,
  output logic             rd_en_o,
  output logic [CH_AW-1:0] rd_addr_o,
  output logic             s1_valid_o,
  output word_kind_e       s1_kind_o,
  output logic [3:0]       s1_hsel_o,
  output logic             s1_first_o,
  output logic             s1_last_o
);
  localparam logic [CNT_W:0]   HDR_END = (CNT_W+1)'(HDR_WORDS);
  localparam logic [CNT_W:0]   CH_END  = (CNT_W+1)'(HDR_WORDS + NCH);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(REC_WORDS - 1);

  logic             busy_q;
  logic [CNT_W-1:0] wcnt_q;
  logic [CNT_W:0]   wide;
  logic             in_hdr, in_ch;

  assign wide      = {1'b0, wcnt_q};
  assign in_hdr    = wide < HDR_END;
  assign in_ch     = !in_hdr && (wide < CH_END);
  assign rd_en_o   = busy_q && in_ch;
  assign rd_addr_o = CH_AW'(wcnt_q - CNT_W'(HDR_WORDS));
  assign busy_o    = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      wcnt_q     <= '0;
      s1_valid_o <= 1'b0;
      s1_kind_o  <= WK_ZERO;
      s1_hsel_o  <= '0;
      s1_first_o <= 1'b0;
      s1_last_o  <= 1'b0;
    end else begin
      if (go_i) begin
        busy_q <= 1'b1;
        wcnt_q <= '0;
      end else if (busy_q) begin
        if (wcnt_q == LAST) begin
          busy_q <= 1'b0;
          wcnt_q <= '0;
        end else begin
          wcnt_q <= wcnt_q + CNT_W'(1);
        end
      end
      s1_valid_o <= busy_q;
      s1_kind_o  <= in_hdr ? WK_HDR : (in_ch ? WK_CHAN : WK_ZERO);
      s1_hsel_o  <= wcnt_q[3:0];
      s1_first_o <= busy_q && (wcnt_q == '0);
      s1_last_o  <= busy_q && (wcnt_q == LAST);
    end
  end

  // R5: the word counter advances once per cycle inside a record
  p_walk_step_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && wcnt_q != LAST) |=> (busy_q && wcnt_q == $past(wcnt_q) + CNT_W'(1)));

  // R9: a fetch cycle is followed by a channel word in the output stage
  p_fetch_kind_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en_o |=> (s1_valid_o && s1_kind_o == WK_CHAN));
endmodule

// File: rtl/sfmt_emit.sv
module sfmt_emit
  import sfmt_pkg::*;
#(
  parameter int BURST_RECS = 128,
  parameter int BP_W       = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            s1_valid_i,
  input  word_kind_e      s1_kind_i,
  input  logic [3:0]      s1_hsel_i,
  input  logic            s1_first_i,
  input  logic            s1_last_i,
  input  logic [63:0]     ses_i,
  input  logic [31:0]     unit_i,
  input  logic [31:0]     idx_i,
  input  logic [31:0]     map_i,
  input  logic [BP_W-1:0] bpos_i,
  input  logic [15:0]     rd_data_i,
  output logic            out_valid_o,
  output logic [15:0]     out_data_o,
  output logic            out_sor_o,
  output logic            out_eor_o,
  output logic            out_sob_o,
  output logic            out_eob_o
);
  localparam logic [BP_W-1:0] BP_LAST = BP_W'(BURST_RECS - 1);

  logic [15:0] hdr_word;

  always_comb begin
    case (s1_hsel_i)
      4'd0:    hdr_word = ses_i[15:0];
      4'd1:    hdr_word = ses_i[31:16];
      4'd2:    hdr_word = ses_i[47:32];
      4'd3:    hdr_word = ses_i[63:48];
      4'd4:    hdr_word = unit_i[15:0];
      4'd5:    hdr_word = unit_i[31:16];
      4'd6:    hdr_word = idx_i[15:0];
      4'd7:    hdr_word = idx_i[31:16];
      4'd8:    hdr_word = map_i[15:0];
      4'd9:    hdr_word = map_i[31:16];
      default: hdr_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_sor_o   <= 1'b0;
      out_eor_o   <= 1'b0;
      out_sob_o   <= 1'b0;
      out_eob_o   <= 1'b0;
    end else begin
      out_valid_o <= s1_valid_i;
      if (!s1_valid_i)              out_data_o <= '0;
      else if (s1_kind_i == WK_HDR)  out_data_o <= hdr_word;
      else if (s1_kind_i == WK_CHAN) out_data_o <= rd_data_i;
      else                           out_data_o <= '0;
      out_sor_o <= s1_valid_i && s1_first_i;
      out_eor_o <= s1_valid_i && s1_last_i;
      out_sob_o <= s1_valid_i && s1_first_i && (bpos_i == '0);
      out_eob_o <= s1_valid_i && s1_last_i && (bpos_i == BP_LAST);
    end
  end

  // R6: burst markers sit on record boundaries
  p_sob_on_sor_r6: assert property (@(posedge clk) disable iff (rst)
    out_sob_o |-> (out_sor_o && out_valid_o));
  p_eob_on_eor_r6: assert property (@(posedge clk) disable iff (rst)
    out_eob_o |-> (out_eor_o && out_valid_o));

  // R5: no gap and no new record before the current one ends
  p_contig_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_eor_o) |=> (out_valid_o && !out_sor_o));
endmodule

// File: rtl/acq_frame_fmt.sv
module acq_frame_fmt
  import sfmt_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int PRI_CH      = 1024,
  parameter int AUX_PER_SRC = 3,
  parameter int REC_BYTES   = 4096,
  parameter int BURST_RECS  = 128,
  localparam int AUX_CH     = NUM_SRC * AUX_PER_SRC,
  localparam int NCH        = PRI_CH + AUX_CH,
  localparam int REC_WORDS  = REC_BYTES / 2,
  localparam int CH_AW      = $clog2(NCH),
  localparam int CNT_W      = $clog2(REC_WORDS),
  localparam int BP_W       = (BURST_RECS > 1) ? $clog2(BURST_RECS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [63:0]        session_i,
  input  logic [31:0]        unit_i,
  input  logic [NUM_SRC-1:0] src_active_i,
  input  logic               sample_rdy_i,
  output logic               buf_rd_en_o,
  output logic [CH_AW-1:0]   buf_rd_addr_o,
  input  logic [15:0]        buf_rd_data_i,
  output logic               out_valid_o,
  output logic [15:0]        out_data_o,
  output logic               out_sor_o,
  output logic               out_eor_o,
  output logic               out_sob_o,
  output logic               out_eob_o,
  output logic               recording_o,
  output logic               overrun_o
);
  logic            go, busy;
  logic [63:0]     ses;
  logic [31:0]     unit, idx, map;
  logic [BP_W-1:0] bpos;
  logic            s1_valid, s1_first, s1_last;
  word_kind_e      s1_kind;
  logic [3:0]      s1_hsel;

  sfmt_ctrl #(.NUM_SRC(NUM_SRC), .BURST_RECS(BURST_RECS), .BP_W(BP_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .session_i(session_i), .unit_i(unit_i), .src_active_i(src_active_i),
    .sample_rdy_i(sample_rdy_i), .busy_i(busy), .go_o(go),
    .recording_o(recording_o), .overrun_o(overrun_o), .ses_o(ses),
    .unit_o(unit), .idx_o(idx), .map_o(map), .bpos_o(bpos)
  );

  sfmt_walk #(.NCH(NCH), .REC_WORDS(REC_WORDS), .CH_AW(CH_AW), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst(rst), .go_i(go), .busy_o(busy),
    .rd_en_o(buf_rd_en_o), .rd_addr_o(buf_rd_addr_o),
    .s1_valid_o(s1_valid), .s1_kind_o(s1_kind), .s1_hsel_o(s1_hsel),
    .s1_first_o(s1_first), .s1_last_o(s1_last)
  );

  sfmt_emit #(.BURST_RECS(BURST_RECS), .BP_W(BP_W)) u_emit (
    .clk(clk), .rst(rst), .s1_valid_i(s1_valid), .s1_kind_i(s1_kind),
    .s1_hsel_i(s1_hsel), .s1_first_i(s1_first), .s1_last_i(s1_last),
    .ses_i(ses), .unit_i(unit), .idx_i(idx), .map_i(map), .bpos_i(bpos),
    .rd_data_i(buf_rd_data_i), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o), .out_sor_o(out_sor_o), .out_eor_o(out_eor_o),
    .out_sob_o(out_sob_o), .out_eob_o(out_eob_o)
  );

  // R10: nothing is emitted directly after reset
  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> (!out_valid_o && !recording_o && !overrun_o));
endmodule

// File: tb/acq_frame_fmt_bench.sv
module acq_frame_fmt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC = 4;
  localparam int PRI_CH  = 8;
  localparam int AUX_PS  = 3;
  localparam int REC_B   = 64;
  localparam int BURST   = 4;
  localparam int NCH     = PRI_CH + NUM_SRC * AUX_PS;
  localparam int REC_W   = REC_B / 2;
  localparam int CH_AW   = $clog2(NCH);

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst = 1'b1, start = 1'b0, stop = 1'b0, rdy = 1'b0;
  logic [63:0] session = '0;
  logic [31:0] unit = '0;
  logic [NUM_SRC-1:0] srcmap = '0;
  logic rd_en;
  logic [CH_AW-1:0] rd_addr;
  logic [15:0] rd_data = '0;
  logic ov, od_sor, od_eor, od_sob, od_eob, recording, overrun;
  logic [15:0] od;

  acq_frame_fmt #(.NUM_SRC(NUM_SRC), .PRI_CH(PRI_CH), .AUX_PER_SRC(AUX_PS),
                  .REC_BYTES(REC_B), .BURST_RECS(BURST)) u_acq_frame_fmt (
    .clk(clk), .rst(rst), .start_i(start), .stop_i(stop), .session_i(session),
    .unit_i(unit), .src_active_i(srcmap), .sample_rdy_i(rdy),
    .buf_rd_en_o(rd_en), .buf_rd_addr_o(rd_addr), .buf_rd_data_i(rd_data),
    .out_valid_o(ov), .out_data_o(od), .out_sor_o(od_sor), .out_eor_o(od_eor),
    .out_sob_o(od_sob), .out_eob_o(od_eob), .recording_o(recording),
    .overrun_o(overrun)
  );

  logic [15:0] mem [NCH];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  int total = 0, bad = 0;
  bit finished = 1'b0;
  bit in_rec = 1'b0;
  logic [15:0] exp_d[$];
  logic [3:0]  exp_f[$];
  string       exp_t[$];
  logic [63:0] m_ses;
  logic [31:0] m_unit, m_idx;
  int          m_bpos;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference stream compared every clock
  always @(negedge clk) begin
    logic [15:0] d;
    logic [3:0]  f;
    string       t;
    if (!rst) begin
      if (ov) begin
        if (exp_d.size() == 0) begin
          chk(1'b0, "R8", "word with no record expected", od, 0);
        end else begin
          d = exp_d.pop_front(); f = exp_f.pop_front(); t = exp_t.pop_front();
          chk(od == d, t, "record word", od, d);
          chk({od_sor, od_eor} == f[3:2], "R5", "record markers", {od_sor, od_eor}, f[3:2]);
          chk({od_sob, od_eob} == f[1:0], "R6", "burst markers", {od_sob, od_eob}, f[1:0]);
        end
        in_rec = !od_eor;
      end else if (in_rec) begin
        chk(1'b0, "R5", "gap inside record", 0, 1);
        in_rec = 1'b0;
      end
    end
  end

  task automatic push_rec(input logic [NUM_SRC-1:0] map);
    logic [31:0] map32;
    map32 = 32'(map);
    for (int w = 0; w < REC_W; w++) begin
      logic [15:0] v;
      string t;
      if (w < 4)               begin v = m_ses[16*w +: 16];      t = "R3"; end
      else if (w < 6)          begin v = m_unit[16*(w-4) +: 16]; t = "R3"; end
      else if (w < 8)          begin v = m_idx[16*(w-6) +: 16];  t = "R2"; end
      else if (w < 10)         begin v = map32[16*(w-8) +: 16];  t = "R4"; end
      else if (w < 10 + NCH)   begin v = mem[w-10];              t = "R9"; end
      else                     begin v = 16'h0;                  t = "R1"; end
      exp_d.push_back(v);
      exp_t.push_back(t);
      exp_f.push_back({w == 0, w == REC_W-1, w == 0 && m_bpos == 0,
                       w == REC_W-1 && m_bpos == BURST-1});
    end
    m_idx  = m_idx + 1;
    m_bpos = (m_bpos + 1) % BURST;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < NCH; i++) mem[i] = 16'((seed * 16'h0101) ^ (i * 16'h0913) ^ 16'h5a00);
  endtask

  task automatic do_start(input logic [63:0] s, input logic [31:0] u);
    @(negedge clk); session = s; unit = u; start = 1'b1;
    @(negedge clk); start = 1'b0;
    m_ses = s; m_unit = u; m_idx = 0; m_bpos = 0;
  endtask

  task automatic strobe();
    @(negedge clk); rdy = 1'b1;
    @(negedge clk); rdy = 1'b0;
  endtask

  task automatic record(input logic [NUM_SRC-1:0] map, input int seed);
    fill(seed);
    @(negedge clk); srcmap = map; rdy = 1'b1;
    push_rec(map);
    @(negedge clk); rdy = 1'b0; srcmap = ~map;
    repeat (REC_W + 6) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    chk(!ov && !recording && !overrun, "R10", "reset state", {ov, recording, overrun}, 0);
    @(negedge clk); rst = 1'b0;
    // R8: strobe before any start
    strobe();
    repeat (REC_W + 6) @(negedge clk);
    chk(!recording, "R8", "idle recording flag", recording, 0);
    do_start(64'h1122334455667788, 32'hCAFE0123);
    chk(recording, "R2", "recording after start", recording, 1);
    record(4'b1010, 1);
    record(4'b0101, 2);
    record(4'b1111, 3);
    // R3: new tag with start while recording is ignored
    @(negedge clk); session = 64'hDEAD_BEEF_0000_0001; unit = 32'h0BAD0BAD; start = 1'b1;
    @(negedge clk); start = 1'b0;
    record(4'b0001, 4);
    record(4'b1000, 5);
    chk(!overrun, "R7", "no overrun yet", overrun, 0);
    // R7: second strobe inside a record
    fill(6);
    @(negedge clk); srcmap = 4'b0110; rdy = 1'b1;
    push_rec(4'b0110);
    @(negedge clk); rdy = 1'b0;
    repeat (4) @(negedge clk);
    rdy = 1'b1;
    @(negedge clk); rdy = 1'b0;
    chk(overrun, "R7", "overrun set", overrun, 1);
    repeat (REC_W + 6) @(negedge clk);
    record(4'b0011, 7);
    chk(overrun, "R7", "overrun sticky", overrun, 1);
    // R8: stop during a record lets it finish
    fill(8);
    @(negedge clk); srcmap = 4'b1100; rdy = 1'b1;
    push_rec(4'b1100);
    @(negedge clk); rdy = 1'b0;
    repeat (3) @(negedge clk);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk(!recording, "R8", "recording after stop", recording, 0);
    repeat (REC_W + 6) @(negedge clk);
    strobe();
    repeat (REC_W + 6) @(negedge clk);
    // restart: index and burst position from zero, overrun cleared
    do_start(64'h0F0E0D0C0B0A0908, 32'h76543210);
    chk(!overrun, "R7", "overrun cleared by start", overrun, 0);
    record(4'b1001, 9);
    record(4'b0111, 10);
    repeat (4) @(negedge clk);
    chk(exp_d.size() == 0, "R5", "all expected words seen", exp_d.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule